// File: doc/BRIEF.md
# Direct I/O Port Bus Sequencer

This block runs the bus side of a two-byte port transfer instruction for an 8-bit processor with a multiplexed address/data bus. When `start` is accepted, it captures the program counter, the accumulator and the direction of the transfer. It then runs three machine cycles back to back:

- an opcode fetch of four clock states (OF1..OF4);
- an operand read of three states (OR1..OR3), which takes the port number from the data bus into a temporary register;
- a port transfer of three states (XF1..XF3), which reads or writes the port.

The block drives:

- the low address or data byte on a multiplexed bus, with its own drive enable;
- the high address byte;
- an address latch enable;
- a memory/port select;
- active-low read and write strobes.

The operand byte held in the temporary register is the port number. During the transfer it appears on both halves of the 16-bit address. For an output transfer the latched accumulator is driven on the bus while the write strobe is low. For an input transfer the byte on the data bus at the end of XF3 is returned on `rd_byte` with a one-cycle `done` pulse. The program counter copy steps once after the fetch and once after the operand read. The updated value is visible on `pc_out`.

States and transitions:

- IDLE goes to OF1 on an accepted `start`.
- OF1 to OF2 to OF3 to OF4 to OR1 to OR2 to OR3 to XF1 to XF2 to XF3 run unconditionally, one per clock.
- XF3 returns to IDLE.
- A `start` seen in any state other than IDLE is ignored.
- A `start` held high in the IDLE cycle that carries `done` begins the next instruction at once.

Top module: `io_port_seq`

## Requirements
- R1: After reset, and in every IDLE cycle, the outputs are as follows. `busy`, `ale`, `io_sel`, `ad_oe` and `done` are 0. `rd_n` and `wr_n` are 1. `ad_out` and `a_hi` are 0. After reset `rd_byte` and `pc_out` are 0.
- R2: A `start` sampled high in IDLE begins an instruction. `busy` is then high for exactly 10 clock states: 4 for the fetch, 3 for the operand read and 3 for the transfer. A `start` while busy has no effect on the sequence or on the latched operands.
- R3: `ale` is 1 only in the first state of each machine cycle (states 1, 5 and 8 of the instruction). In those states `ad_oe` is 1 and both strobes are inactive.
- R4: The fetch presents the start PC: low byte on `ad_out` in state 1, high byte on `a_hi` in states 1 to 4. The operand read presents PC+1 in the same way in states 5 to 7. From state 8 onward `pc_out` is PC+2.
- R5: In the transfer cycle (states 8 to 10) `io_sel` is 1 and `a_hi` carries the port number. In state 8 `ad_out` also carries the port number. `io_sel` is 0 in every other state.
- R6: `rd_n` is 0 in states 2, 3, 6 and 7, and also in states 9 and 10 of an input transfer (`is_out`=0). `wr_n` is 0 only in states 9 and 10 of an output transfer (`is_out`=1). The two strobes are never low together.
- R7: In states 9 and 10 of an output transfer, `ad_oe` is 1 and `ad_out` equals the accumulator latched at start. In all other non-ALE states `ad_oe` is 0 and `ad_out` is 0.
- R8: `done` is 1 for exactly the one cycle after state 10. For an input transfer, `rd_byte` then holds the value of `din` sampled at the end of state 10. For an output transfer, `rd_byte` keeps its previous value.
- R9: The port number is the value of `din` sampled at the end of state 7.
- R10: The PC steps wrap modulo 2^16. A start PC of 0xFFFF fetches at 0xFFFF, reads the operand at 0x0000 and ends with `pc_out` = 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (accepted in IDLE only) |
| is_out | input | 1 | Transfer class: 0 port input, 1 port output |
| pc_in | input | 16 | Program counter at the opcode |
| acc_in | input | 8 | Accumulator value for an output transfer |
| din | input | 8 | Data bus input |
| ad_out | output | 8 | Multiplexed low address / write data |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| a_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch enable |
| io_sel | output | 1 | 1 for a port cycle, 0 for a memory cycle |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_byte | output | 8 | Byte returned by an input transfer |
| pc_out | output | 16 | Program counter after the steps |

## Verification
The assertions assume that `din` is stable around the rising edge that ends states 7 and 10. They assume that `rst_n` is the only way to abort a sequence, and that `start` and `is_out` are ordinary synchronous levels. The bench changes every input only on the falling clock edge. It draws `din` afresh each cycle, and it raises `start` freely during busy periods, including holding it high across several instructions. Reset is asserted only in separate windows, one of them in the middle of an instruction.

// File: rtl/io_seq_pkg.sv
package io_seq_pkg;

    // One encoding per clock state of the 4+3+3 sequence.
    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_OF1  = 4'd1,
        ST_OF2  = 4'd2,
        ST_OF3  = 4'd3,
        ST_OF4  = 4'd4,
        ST_OR1  = 4'd5,
        ST_OR2  = 4'd6,
        ST_OR3  = 4'd7,
        ST_XF1  = 4'd8,
        ST_XF2  = 4'd9,
        ST_XF3  = 4'd10
    } seq_state_e;

endpackage

// File: rtl/io_seq_fsm.sv
module io_seq_fsm
    import io_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output seq_state_e state,
    output logic       accept,
    output logic       busy
);

    seq_state_e st_q;
    seq_state_e st_d;

    assign accept = start && (st_q == ST_IDLE);
    assign busy   = (st_q != ST_IDLE);
    assign state  = st_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (accept) st_d = ST_OF1;
            ST_OF1:  st_d = ST_OF2;
            ST_OF2:  st_d = ST_OF3;
            ST_OF3:  st_d = ST_OF4;
            ST_OF4:  st_d = ST_OR1;
            ST_OR1:  st_d = ST_OR2;
            ST_OR2:  st_d = ST_OR3;
            ST_OR3:  st_d = ST_XF1;
            ST_XF1:  st_d = ST_XF2;
            ST_XF2:  st_d = ST_XF3;
            ST_XF3:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // R2: a sequence, once begun, runs to XF3 before going idle.
    a_r2_no_early_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && st_q != ST_XF3) |=> (st_q != ST_IDLE));

    // R2: XF3 is always followed by IDLE.
    a_r2_xf3_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_XF3) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/io_seq_regs.sv
module io_seq_regs
    import io_seq_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_state_e    state,
    input  logic          accept,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] acc_in,
    input  logic          is_out,
    input  logic [DW-1:0] din,
    output logic [AW-1:0] pc_q,
    output logic [DW-1:0] acc_q,
    output logic          dir_out_q,
    output logic [DW-1:0] port_q,
    output logic [DW-1:0] rd_byte,
    output logic          done
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q      <= '0;
            acc_q     <= '0;
            dir_out_q <= 1'b0;
            port_q    <= '0;
            rd_byte   <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                pc_q      <= pc_in;
                acc_q     <= acc_in;
                dir_out_q <= is_out;
            end
            unique case (state)
                ST_OF4: pc_q <= pc_q + AW'(1);
                ST_OR3: begin
                    port_q <= din;
                    pc_q   <= pc_q + AW'(1);
                end
                ST_XF3: begin
                    done <= 1'b1;
                    if (!dir_out_q) rd_byte <= din;
                end
                default: ;
            endcase
        end
    end

    // R8: done lasts one cycle.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: the operand read address is one above the fetch address.
    a_r4_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OR1) |-> (pc_q == $past(pc_q) + AW'(1)));

    // R9: the port register takes the bus byte from the end of OR3.
    a_r9_port_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XF1) |-> (port_q == $past(din)));

    // R2: latched operands stay put while the sequence runs.
    a_r2_acc_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(acc_q) && $stable(dir_out_q));

endmodule

// File: rtl/io_seq_bus.sv
module io_seq_bus
    import io_seq_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  seq_state_e    state,
    input  logic [AW-1:0] pc_q,
    input  logic [DW-1:0] acc_q,
    input  logic          dir_out_q,
    input  logic [DW-1:0] port_q,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic [DW-1:0] a_hi,
    output logic          ale,
    output logic          io_sel,
    output logic          rd_n,
    output logic          wr_n
);

    logic [DW-1:0] pc_lo;
    logic [DW-1:0] pc_hi;

    assign pc_lo = pc_q[DW-1:0];
    assign pc_hi = pc_q[AW-1:DW];

    // Output decode
    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        a_hi   = '0;
        ale    = 1'b0;
        io_sel = 1'b0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        unique case (state)
            ST_IDLE: ;
            ST_OF1, ST_OR1: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = pc_lo;
                a_hi   = pc_hi;
            end
            ST_OF2, ST_OF3, ST_OR2, ST_OR3: begin
                a_hi = pc_hi;
                rd_n = 1'b0;
            end
            ST_OF4: begin
                a_hi = pc_hi;
            end
            ST_XF1: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = port_q;
                a_hi   = port_q;
                io_sel = 1'b1;
            end
            ST_XF2, ST_XF3: begin
                a_hi   = port_q;
                io_sel = 1'b1;
                if (dir_out_q) begin
                    wr_n   = 1'b0;
                    ad_oe  = 1'b1;
                    ad_out = acc_q;
                end else begin
                    rd_n = 1'b0;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/io_port_seq.sv
module io_port_seq
    import io_seq_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_out,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic [DW-1:0] a_hi,
    output logic          ale,
    output logic          io_sel,
    output logic          rd_n,
    output logic          wr_n,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_byte,
    output logic [AW-1:0] pc_out
);

    seq_state_e    state;
    logic          accept;
    logic [AW-1:0] pc_q;
    logic [DW-1:0] acc_q;
    logic          dir_out_q;
    logic [DW-1:0] port_q;

    io_seq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .state  (state),
        .accept (accept),
        .busy   (busy)
    );

    io_seq_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .accept    (accept),
        .pc_in     (pc_in),
        .acc_in    (acc_in),
        .is_out    (is_out),
        .din       (din),
        .pc_q      (pc_q),
        .acc_q     (acc_q),
        .dir_out_q (dir_out_q),
        .port_q    (port_q),
        .rd_byte   (rd_byte),
        .done      (done)
    );

    io_seq_bus #(.DW(DW)) u_bus (
        .state     (state),
        .pc_q      (pc_q),
        .acc_q     (acc_q),
        .dir_out_q (dir_out_q),
        .port_q    (port_q),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .a_hi      (a_hi),
        .ale       (ale),
        .io_sel    (io_sel),
        .rd_n      (rd_n),
        .wr_n      (wr_n)
    );

    assign pc_out = pc_q;

    // R6: never both strobes low.
    a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R3: address phase keeps both strobes inactive and drives the bus.
    a_r3_ale_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && ad_oe));

    // R3: ale lasts a single state.
    a_r3_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R5: port cycle opens with an address phase showing the port on both halves.
    a_r5_port_both: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_sel) |-> (ale && ad_out == a_hi));

    // R7: write strobe always comes with the bus driven.
    a_r7_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (ad_oe && io_sel));

    // R1: idle means quiet bus.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_n && wr_n && !ale && !io_sel && !ad_oe));

endmodule

// File: tb/io_port_seq_tb.sv
module io_port_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_out = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  acc_in = '0;
    logic [7:0]  din = '0;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  a_hi;
    logic        ale;
    logic        io_sel;
    logic        rd_n;
    logic        wr_n;
    logic        busy;
    logic        done;
    logic [7:0]  rd_byte;
    logic [15:0] pc_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit compare_en = 1'b0;

    always #5 clk = ~clk;

    io_port_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_out(is_out),
        .pc_in(pc_in), .acc_in(acc_in), .din(din),
        .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale),
        .io_sel(io_sel), .rd_n(rd_n), .wr_n(wr_n), .busy(busy),
        .done(done), .rd_byte(rd_byte), .pc_out(pc_out)
    );

    // Behavioural reference: phase 0 idle, 1..10 the clock states.
    int       m_ph   = 0;
    int       m_pc   = 0;
    int       m_acc  = 0;
    bit       m_out  = 0;
    int       m_port = 0;
    int       m_rd   = 0;
    bit       m_done = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_pc = 0; m_acc = 0; m_out = 0;
            m_port = 0; m_rd = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_ph == 0) begin
                if (start) begin
                    m_ph = 1; m_pc = pc_in; m_acc = acc_in; m_out = is_out;
                end
            end else if (m_ph == 4) begin
                m_pc = (m_pc + 1) % 65536; m_ph = 5;
            end else if (m_ph == 7) begin
                m_port = din; m_pc = (m_pc + 1) % 65536; m_ph = 8;
            end else if (m_ph == 10) begin
                if (!m_out) m_rd = din;
                m_done = 1; m_ph = 0;
            end else begin
                m_ph = m_ph + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h (phase %0d)", req, what, act, exp, m_ph);
        end
    endtask

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (compare_en && rst_n) begin
            bit e_ale, e_io, e_rd, e_wr, e_oe;
            int e_ad, e_hi;
            e_ale = (m_ph == 1 || m_ph == 5 || m_ph == 8);
            e_io  = (m_ph >= 8);
            e_rd  = !((m_ph == 2 || m_ph == 3 || m_ph == 6 || m_ph == 7) ||
                      (!m_out && (m_ph == 9 || m_ph == 10)));
            e_wr  = !(m_out && (m_ph == 9 || m_ph == 10));
            e_oe  = e_ale || (m_out && (m_ph == 9 || m_ph == 10));
            e_ad  = 0;
            if (m_ph == 1 || m_ph == 5) e_ad = m_pc % 256;
            if (m_ph == 8) e_ad = m_port;
            if (m_out && (m_ph == 9 || m_ph == 10)) e_ad = m_acc;
            e_hi = 0;
            if (m_ph >= 1 && m_ph <= 7) e_hi = m_pc / 256;
            if (m_ph >= 8) e_hi = m_port;
            chk("R2", "busy", busy, m_ph != 0);
            chk("R3", "ale", ale, e_ale);
            chk("R5", "io_sel", io_sel, e_io);
            chk("R6", "rd_n", rd_n, e_rd);
            chk("R6", "wr_n", wr_n, e_wr);
            chk("R7", "ad_oe", ad_oe, e_oe);
            chk("R4", "ad_out", ad_out, e_ad);
            chk("R5", "a_hi", a_hi, e_hi);
            chk("R8", "done", done, m_done);
            chk("R8", "rd_byte", rd_byte, m_rd);
            chk("R10", "pc_out", pc_out, m_pc);
        end
    end

    // Fresh data bus byte each cycle.
    always @(negedge clk) din <= 8'($urandom_range(0, 255));

    task automatic run_instr(input bit dir, input int pc, input int acc);
        @(negedge clk);
        start = 1'b1; is_out = dir; pc_in = 16'(pc); acc_in = 8'(acc);
        @(negedge clk);
        start = 1'b0;
        repeat (11) @(negedge clk);
    endtask

    task automatic wrap_up;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
                wrap_up();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset busy", busy, 0);
        chk("R1", "reset rd_n", rd_n, 1);
        chk("R1", "reset wr_n", wr_n, 1);
        chk("R1", "reset ale", ale, 0);
        chk("R1", "reset pc_out", pc_out, 0);
        chk("R1", "reset rd_byte", rd_byte, 0);
        rst_n = 1'b1;
        compare_en = 1'b1;
        @(negedge clk);

        // R9/R8: input transfer; R7: output transfer
        run_instr(1'b0, 16'h1234, 8'h00);
        run_instr(1'b1, 16'h2000, 8'hA5);
        // R10: wrap of the PC steps
        run_instr(1'b0, 16'hFFFF, 8'h3C);
        chk("R10", "wrapped pc", pc_out, 16'h0001);
        run_instr(1'b1, 16'hFFFF, 8'h5A);

        // R2: start held high across several instructions
        @(negedge clk);
        start = 1'b1; is_out = 1'b1; pc_in = 16'h4000; acc_in = 8'h11;
        repeat (3) begin
            repeat (4) @(negedge clk);
            pc_in = pc_in + 16'h0100; acc_in = acc_in + 8'h22;
            is_out = ~is_out;
        end
        repeat (30) @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);

        // Random mix with spurious starts while busy
        for (int i = 0; i < 150; i++) begin
            start  = ($urandom_range(0, 2) != 0);
            is_out = 1'($urandom_range(0, 1));
            pc_in  = 16'($urandom_range(0, 65535));
            acc_in = 8'($urandom_range(0, 255));
            repeat ($urandom_range(1, 6)) @(negedge clk);
        end
        start = 1'b0;
        repeat (12) @(negedge clk);

        // R1: reset in the middle of an instruction
        start = 1'b1; is_out = 1'b1; pc_in = 16'h7777; acc_in = 8'h99;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        #2 rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "mid reset busy", busy, 0);
        chk("R1", "mid reset io_sel", io_sel, 0);
        chk("R1", "mid reset pc_out", pc_out, 0);
        #2 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_instr(1'b0, 16'h0102, 8'h00);
        wrap_up();
    end

endmodule